// File: doc/BRIEF.md
# Serial Configuration Word Loader

This block is the configuration port of a frequency synthesizer control core. An external host drives three pins: a serial clock, a serial data line and a load strobe. The block samples all three into the system clock domain and builds a 24-bit word from the data line, one bit on each rising serial clock edge, with the most significant bit first. A rising edge on the load strobe commits the word to one of four configuration registers. The two bits shifted in last select the register.

The four registers hold the feedback divider setting, the reference divider setting, the general control word and the noise/spur setting. They drive the rest of the chip as parallel buses. For each register there is a write strobe that pulses for one system clock in the cycle its new value first appears, so that downstream logic can pick up a new divider value. The serial pins carry no flow control. The host must keep each pin level stable for at least two system clocks between edges, and nothing in the block can stall it. All other pins are plain levels.

Top module: `serial_cfg_port`

## Requirements
- R1: While reset is asserted, and after it is released, all four configuration registers and the holding shift register read zero, and no write strobe is high.
- R2: On each rising serial clock edge, the synchronized data bit enters the holding register at bit 0 and the existing contents move up one place, so a 24-bit word arrives MSB (bit 23) first.
- R3: On a rising edge of the load strobe, the holding word is copied in full into the register that its bits [1:0] select: 0 = feedback divider, 1 = reference divider, 2 = control, 3 = noise/spur.
- R4: A commit changes only the addressed register, and the other three keep their contents.
- R5: Each commit pulses exactly one write strobe, `cfg_wr_stb[a]` where a is the address, for a single system clock in the cycle the new value appears. At most one strobe bit is high at any time.
- R6: If more than 24 bits are shifted before a commit, the oldest bits are lost and only the last 24 received are committed.
- R7: Falling serial clock edges, and data toggles while the serial clock is steady, do not change the holding register.
- R8: Without a rising load strobe edge, no register changes and no strobe pulses. Holding the load strobe high commits only once.
- R9: A commit does not clear the holding register. A word shorter than 24 bits is therefore committed together with the older bits still held from earlier words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock from host (asynchronous) |
| ser_dat | input | 1 | Serial data from host (asynchronous) |
| ser_le | input | 1 | Load strobe from host (asynchronous) |
| cfg_ndiv | output | 24 | Feedback divider register (address 0) |
| cfg_rdiv | output | 24 | Reference divider register (address 1) |
| cfg_ctrl | output | 24 | Control register (address 2) |
| cfg_noise | output | 24 | Noise/spur register (address 3) |
| cfg_wr_stb | output | 4 | One-cycle update strobe per register, bit index = address |

## Verification
The hardest case to reach from the ports is the holding register after a commit, because its contents never show until the next commit. The stimulus exposes it by sending a word of only eight bits and by committing with no new bits at all after the data line has toggled and the serial clock has fallen. The committed value then shows the leftover bits, and the bench checks them against its own bit-level model. Overflow is covered by placing junk bits in front of a full word. A long load strobe pulse confirms that only one commit takes place.

// File: rtl/serial_cfg_pkg.sv
package serial_cfg_pkg;
  localparam int CFG_WORD_W = 24;
  localparam int CFG_ADDR_W = 2;
  localparam int CFG_NUM_REGS = 1 << CFG_ADDR_W;

  typedef enum logic [CFG_ADDR_W-1:0] {
    ADDR_NDIV  = 2'd0,
    ADDR_RDIV  = 2'd1,
    ADDR_CTRL  = 2'd2,
    ADDR_NOISE = 2'd3
  } cfg_addr_e;
endpackage

// File: rtl/serial_cfg_sync.sv
module serial_cfg_sync #(
  parameter int NBITS  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] pin_i,
  output logic [NBITS-1:0] lvl_o,
  output logic [NBITS-1:0] rise_o
);
  logic [NBITS-1:0] pipe_q [STAGES];
  logic [NBITS-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe_q[i] <= '0;
      prev_q <= '0;
    end else begin
      pipe_q[0] <= pin_i;
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
      prev_q <= pipe_q[STAGES-1];
    end
  end

  assign lvl_o  = pipe_q[STAGES-1];
  assign rise_o = lvl_o & ~prev_q;
endmodule

// File: rtl/serial_cfg_shift.sv
module serial_cfg_shift #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word_q <= '0;
    else if (shift_en) word_q <= {word_q[WORD_W-2:0], bit_i};
  end

  assign word_o = word_q;

  // R2: new bit lands at bit 0, older bits move up one place
  a_r2_shift_order: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (word_q == {$past(word_q[WORD_W-2:0]), $past(bit_i)}));

  // R7: without a shift pulse the holding word stays put
  a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(word_q));
endmodule

// File: rtl/serial_cfg_bank.sv
module serial_cfg_bank #(
  parameter int WORD_W = 24,
  parameter int ADDR_W = 2,
  localparam int NREGS = 1 << ADDR_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         commit_i,
  input  logic [WORD_W-1:0]            word_i,
  output logic [NREGS-1:0][WORD_W-1:0] regs_o,
  output logic [NREGS-1:0]             stb_o
);
  logic [ADDR_W-1:0] sel;
  assign sel = word_i[ADDR_W-1:0];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    logic hit;
    assign hit = commit_i && (sel == ADDR_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_o[g] <= '0;
        stb_o[g]  <= 1'b0;
      end else begin
        stb_o[g] <= hit;
        if (hit) regs_o[g] <= word_i;
      end
    end
  end

  // R5: never more than one strobe bit at a time
  a_r5_stb_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb_o));

  // R5: a strobe lasts one cycle only
  a_r5_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_o != '0) |=> (stb_o == '0));

  // R8: no strobe follows a cycle with no commit
  a_r8_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> (stb_o == '0));

  // R4: registers change only together with a strobe
  a_r4_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_o == '0) |-> (regs_o == $past(regs_o)));
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
  import serial_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ser_clk,
  input  logic                  ser_dat,
  input  logic                  ser_le,
  output logic [CFG_WORD_W-1:0] cfg_ndiv,
  output logic [CFG_WORD_W-1:0] cfg_rdiv,
  output logic [CFG_WORD_W-1:0] cfg_ctrl,
  output logic [CFG_WORD_W-1:0] cfg_noise,
  output logic [CFG_NUM_REGS-1:0] cfg_wr_stb
);
  localparam int PIN_DAT = 0;
  localparam int PIN_CLK = 1;
  localparam int PIN_LE  = 2;

  logic [2:0] lvl, rise;
  logic [CFG_WORD_W-1:0] hold_word;
  logic [CFG_NUM_REGS-1:0][CFG_WORD_W-1:0] regs;
  logic unused_sync;

  serial_cfg_sync #(.NBITS(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  ({ser_le, ser_clk, ser_dat}),
    .lvl_o  (lvl),
    .rise_o (rise)
  );

  assign unused_sync = ^{lvl[PIN_LE], lvl[PIN_CLK], rise[PIN_DAT]};

  serial_cfg_shift #(.WORD_W(CFG_WORD_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (rise[PIN_CLK]),
    .bit_i    (lvl[PIN_DAT]),
    .word_o   (hold_word)
  );

  serial_cfg_bank #(.WORD_W(CFG_WORD_W), .ADDR_W(CFG_ADDR_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit_i (rise[PIN_LE]),
    .word_i   (hold_word),
    .regs_o   (regs),
    .stb_o    (cfg_wr_stb)
  );

  assign cfg_ndiv  = regs[int'(ADDR_NDIV)];
  assign cfg_rdiv  = regs[int'(ADDR_RDIV)];
  assign cfg_ctrl  = regs[int'(ADDR_CTRL)];
  assign cfg_noise = regs[int'(ADDR_NOISE)];
endmodule

// File: tb/serial_cfg_port_bench.sv
module serial_cfg_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;

  typedef struct {
    int          addr;
    logic [23:0] word;
    string       tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0;
  logic [23:0] cfg_ndiv, cfg_rdiv, cfg_ctrl, cfg_noise;
  logic [3:0]  cfg_wr_stb;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;
  item_t exp_q[$];
  logic [23:0] model_regs [4];
  logic [23:0] model_sh;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_cfg_port u_serial_cfg_port (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_le(ser_le),
    .cfg_ndiv(cfg_ndiv), .cfg_rdiv(cfg_rdiv), .cfg_ctrl(cfg_ctrl), .cfg_noise(cfg_noise),
    .cfg_wr_stb(cfg_wr_stb)
  );

  task automatic chk(string tag, logic [23:0] act, logic [23:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] out_of(int a);
    case (a)
      0: return cfg_ndiv;
      1: return cfg_rdiv;
      2: return cfg_ctrl;
      default: return cfg_noise;
    endcase
  endfunction

  task automatic check_all(string tag);
    for (int a = 0; a < 4; a++) chk(tag, out_of(a), model_regs[a]);
    chk(tag, {20'd0, cfg_wr_stb}, 24'd0);
    chk(tag, exp_q.size(), 24'd0);
  endtask

  // Monitor: pop one expected item per strobe and compare
  always @(negedge clk) begin
    if (rst_n && cfg_wr_stb != 4'd0) begin
      if (exp_q.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL R8: actual strobe %b expected none", cfg_wr_stb);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        model_regs[it.addr] = it.word;
        chk("R5", {20'd0, cfg_wr_stb}, 24'd1 << it.addr);
        chk(it.tag, out_of(it.addr), it.word);
        for (int a = 0; a < 4; a++)
          if (a != it.addr) chk("R4", out_of(a), model_regs[a]);
      end
    end
  end

  task automatic send_bit(logic b);
    @(negedge clk); ser_dat = b;
    repeat (HALF) @(negedge clk); ser_clk = 1'b1;
    repeat (HALF) @(negedge clk); ser_clk = 1'b0;
    model_sh = {model_sh[22:0], b};
  endtask

  task automatic send_bits(logic [31:0] v, int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic load(string tag, int hold);
    item_t it;
    it.addr = int'(model_sh[1:0]);
    it.word = model_sh;
    it.tag  = tag;
    exp_q.push_back(it);
    repeat (HALF) @(negedge clk); ser_le = 1'b1;
    repeat (hold) @(negedge clk); ser_le = 1'b0;
    repeat (8) @(negedge clk);
    chk({tag, " drained"}, exp_q.size(), 24'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 4; a++) model_regs[a] = 24'd0;
    model_sh = 24'd0;
    repeat (3) @(negedge clk);
    check_all("R1 in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R1 after reset");

    // R2/R3: one word to each address
    send_bits(32'h123450, 24); load("R3", HALF);
    send_bits(32'hA5A5A1, 24); load("R2", HALF);
    send_bits(32'h0F0F02, 24); load("R3", HALF);
    send_bits(32'hC3C3C7, 24); load("R3", HALF);
    check_all("R4 after four writes");

    // R4: rewrite one register, others unchanged
    send_bits(32'hFFFFFC, 24); load("R4", HALF);

    // R8: full word without load strobe
    send_bits(32'h777776, 24);
    repeat (10) @(negedge clk);
    check_all("R8 no strobe");

    // R8: long load strobe commits once
    load("R8", 40);

    // R6: junk bits ahead of a full word
    send_bits(32'h2B, 6);
    send_bits(32'h5A5A5D, 24); load("R6", HALF);

    // R9: short word mixes with held bits
    send_bits(32'h36, 8); load("R9", HALF);

    // R7: data toggles with clock low, no rising edges
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); ser_dat = ~ser_dat;
      repeat (3) @(negedge clk);
    end
    load("R7", HALF);

    check_all("R4 final");
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule